// File: doc/BRIEF.md
# Winternitz Hash Chain Step Sequencer

This block walks one Winternitz hash chain forward during signature verification. Software gives it a 32-byte chain node taken from a signature, the message chunk value `a`, a code for the Winternitz parameter `w`, and a per-chain context. The block then applies the chain function `w-1-a` times and presents the chain end value. Each application is one SHA-256 compression. The compression itself is done by a unit outside the block, which is reached through a request/response port.

The block builds the complete padded 64-byte message block for every step. It keeps the running digest in a chain register and feeds each returned digest back in as the data for the next step. As a result, the processor writes the inputs once and reads the result once, whatever the chain length.

Two single-block "simple" modes are supported:

- **Tree mode (mode 0).** A 22-byte context and a one-byte step counter precede the digest, so each step hashes 55 bytes. Compression starts from the standard SHA-256 initial vector.
- **Forest mode (mode 1).** The first 18 context bytes and a 32-bit step counter form a 22-byte address. Every step starts from a caller-supplied SHA-256 state, which is the state left after the padded 64-byte public seed was absorbed. That saved state is reused for every step.

Top module: `hc_chain_seq`

## Requirements
- R1: The number of compressions in a chain is `w-1-a`. The `wsel_i` code selects `w`: 0 gives w=4, 1 gives w=16, 2 or 3 gives w=256. `a` is `chunk_i` masked to its low log2(w) bits, so the upper bits of `chunk_i` are ignored.
- R2: In mode 0, each request block is {ctx (22 bytes), step counter (1 byte), chain value (32 bytes), 0x80, 64-bit big-endian length 440}. Block byte 0 sits at `req_block_o[511:504]`, and context byte 0 is `ctx_i[175:168]`. No request is outstanding while `done_o` is high.
- R3: In mode 1, each request block is {ctx bytes 0..17, 32-bit big-endian step counter, chain value (32 bytes), 0x80, one 0x00 byte, 64-bit big-endian length 944}. The request state is `seed_state_i` in mode 1 and the SHA-256 initial vector 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19 in mode 0.
- R4: The step counter field equals `a` in the first request and increases by one in each later request.
- R5: The chain value in the first request is `node_i`. Each later request carries the state returned by the previous response. `result_o` shows the last response once `done_o` is high.
- R6: When `a = w-1`, no request is issued. `done_o` rises in the cycle after the start pulse is sampled, and `result_o` equals `node_i`.
- R7: Once `req_valid_o` is raised, it stays high with `req_block_o` and `req_state_o` unchanged until `req_ready_i` is sampled high.
- R8: A start pulse while a chain is in progress is ignored. Mode, context, seed state and node are captured only when a start is accepted.
- R9: `done_o` and `result_o` stay unchanged until the next start. A start with a nonzero step count clears `done_o` on the next cycle.
- R10: After reset, `done_o` and `req_valid_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle or done |
| mode_i | input | 1 | 0 = tree mode, 1 = forest mode |
| wsel_i | input | 2 | Winternitz parameter code (0: 4, 1: 16, 2/3: 256) |
| chunk_i | input | 8 | Chunk value `a` (masked to log2(w) bits) |
| node_i | input | 256 | Chain start value from the signature |
| ctx_i | input | 176 | Per-chain context bytes, byte 0 in the top bits |
| seed_state_i | input | 256 | SHA-256 state after the seed block (mode 1) |
| req_valid_o | output | 1 | Compression request valid |
| req_ready_i | input | 1 | Compression unit accepts the request |
| req_state_o | output | 256 | Initial state for the compression |
| req_block_o | output | 512 | Padded message block |
| rsp_valid_i | input | 1 | Compression result valid |
| rsp_state_i | input | 256 | Compression output state |
| done_o | output | 1 | Chain end value available |
| result_o | output | 256 | Chain end value |

## Verification
The hardest situation to reach from the ports is a second start pulse that arrives while a request is outstanding, together with changed mode, context and node inputs. A wrong capture there would only show up in later request blocks. The bench provokes this inside long chains, two cycles after every start. Its own compression model stretches the handshake by delaying ready by zero to two cycles and the response by one or two cycles. Every request block is checked field by field against a block built from the values captured at start. The sweep covers every chunk value for w=4 and w=16, and a strided set plus both ends for w=256, in both modes. High chunk bits are set to prove they are masked.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int HC_BLK_BYTES = 64;
   localparam int HC_LEN_BYTES = 8;

   typedef enum logic [1:0] {
      HC_IDLE = 2'd0,
      HC_REQ  = 2'd1,
      HC_WAIT = 2'd2,
      HC_DONE = 2'd3
   } hc_state_e;

   localparam logic [255:0] HC_SHA256_IV = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
   };
endpackage

// File: rtl/hc_step_ctr.sv
module hc_step_ctr #(
   parameter int ITER_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [1:0]        wsel_i,
   input  logic [ITER_W-1:0] chunk_i,
   input  logic              adv_i,
   output logic [ITER_W-1:0] iter_o,
   output logic              last_o,
   output logic              none_o
);
   logic [ITER_W-1:0] mask;
   logic [ITER_W-1:0] a_m;
   logic [ITER_W-1:0] steps;
   logic [ITER_W-1:0] iter_q;
   logic [ITER_W-1:0] remain_q;
   int                lw;

   always_comb begin
      lw = (wsel_i >= 2'd2) ? ITER_W : (2 << wsel_i);
      if (lw > ITER_W) lw = ITER_W;
      mask  = ITER_W'((64'd1 << lw) - 64'd1);
      a_m   = chunk_i & mask;
      steps = mask - a_m;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iter_q   <= '0;
         remain_q <= '0;
      end else if (load_i) begin
         iter_q   <= a_m;
         remain_q <= steps;
      end else if (adv_i) begin
         iter_q   <= iter_q + 1'b1;
         remain_q <= remain_q - 1'b1;
      end
   end

   assign iter_o = iter_q;
   assign last_o = (remain_q == ITER_W'(1));
   assign none_o = (steps == '0);

   assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> (remain_q != '0));
endmodule

// File: rtl/hc_msg_fmt.sv
module hc_msg_fmt
   import hc_pkg::*;
#(
   parameter int CTX_BYTES      = 22,
   parameter int NODE_W         = 256,
   parameter int ITER_W         = 8,
   parameter int SPX_ITER_BYTES = 4,
   parameter bit SPX_ENABLE     = 1'b1
) (
   input  logic                   mode_i,
   input  logic [CTX_BYTES*8-1:0] ctx_i,
   input  logic [ITER_W-1:0]      iter_i,
   input  logic [NODE_W-1:0]      chain_i,
   input  logic [NODE_W-1:0]      seed_i,
   output logic [HC_BLK_BYTES*8-1:0] blk_o,
   output logic [NODE_W-1:0]      init_o
);
   localparam int NODE_BYTES     = NODE_W / 8;
   localparam int LMS_MSG_BYTES  = CTX_BYTES + 1 + NODE_BYTES;
   localparam int SPX_TAIL_BYTES = CTX_BYTES + NODE_BYTES;
   localparam int SPX_MSG_BYTES  = HC_BLK_BYTES + SPX_TAIL_BYTES;
   localparam int SPX_FILL_BYTES = HC_BLK_BYTES - SPX_TAIL_BYTES - 1 - HC_LEN_BYTES;
   localparam int SPX_KEEP_W     = (CTX_BYTES - SPX_ITER_BYTES) * 8;
   localparam int SPX_ITER_W     = SPX_ITER_BYTES * 8;

   if (ITER_W != 8) begin : g_bad_iter
      $error("tree mode step counter field is one byte wide");
   end
   if (LMS_MSG_BYTES + 1 + HC_LEN_BYTES != HC_BLK_BYTES) begin : g_bad_lms
      $error("tree mode message must fill exactly one block");
   end
   if (SPX_FILL_BYTES < 1 || SPX_ITER_W < ITER_W) begin : g_bad_spx
      $error("forest mode layout does not fit one block");
   end

   logic [HC_BLK_BYTES*8-1:0] lms_blk;
   logic [HC_BLK_BYTES*8-1:0] spx_blk;

   assign lms_blk = {ctx_i, iter_i, chain_i, 8'h80,
                     64'(LMS_MSG_BYTES * 8)};
   assign spx_blk = {ctx_i[CTX_BYTES*8-1 -: SPX_KEEP_W],
                     {(SPX_ITER_W-ITER_W){1'b0}}, iter_i, chain_i, 8'h80,
                     {(SPX_FILL_BYTES*8){1'b0}}, 64'(SPX_MSG_BYTES * 8)};

   if (SPX_ENABLE) begin : g_dual
      assign blk_o  = mode_i ? spx_blk : lms_blk;
      assign init_o = mode_i ? seed_i : HC_SHA256_IV[NODE_W-1:0];
   end else begin : g_tree_only
      assign blk_o  = lms_blk;
      assign init_o = HC_SHA256_IV[NODE_W-1:0];
   end
endmodule

// File: rtl/hc_chain_seq.sv
module hc_chain_seq
   import hc_pkg::*;
#(
   parameter int CTX_BYTES      = 22,
   parameter int NODE_W         = 256,
   parameter int ITER_W         = 8,
   parameter int SPX_ITER_BYTES = 4,
   parameter bit SPX_ENABLE     = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      mode_i,
   input  logic [1:0]                wsel_i,
   input  logic [ITER_W-1:0]         chunk_i,
   input  logic [NODE_W-1:0]         node_i,
   input  logic [CTX_BYTES*8-1:0]    ctx_i,
   input  logic [NODE_W-1:0]         seed_state_i,
   output logic                      req_valid_o,
   input  logic                      req_ready_i,
   output logic [NODE_W-1:0]         req_state_o,
   output logic [HC_BLK_BYTES*8-1:0] req_block_o,
   input  logic                      rsp_valid_i,
   input  logic [NODE_W-1:0]         rsp_state_i,
   output logic                      done_o,
   output logic [NODE_W-1:0]         result_o
);
   localparam int CTX_W = CTX_BYTES * 8;

   hc_state_e          st_q;
   logic               accept;
   logic               adv;
   logic               last;
   logic               none;
   logic [ITER_W-1:0]  iter;
   logic [NODE_W-1:0]  chain_q;
   logic [NODE_W-1:0]  seed_q;
   logic [CTX_W-1:0]   ctx_q;
   logic               mode_q;

   assign accept = start_i && (st_q == HC_IDLE || st_q == HC_DONE);
   assign adv    = (st_q == HC_WAIT) && rsp_valid_i;

   hc_step_ctr #(.ITER_W(ITER_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .wsel_i  (wsel_i),
      .chunk_i (chunk_i),
      .adv_i   (adv),
      .iter_o  (iter),
      .last_o  (last),
      .none_o  (none)
   );

   hc_msg_fmt #(
      .CTX_BYTES      (CTX_BYTES),
      .NODE_W         (NODE_W),
      .ITER_W         (ITER_W),
      .SPX_ITER_BYTES (SPX_ITER_BYTES),
      .SPX_ENABLE     (SPX_ENABLE)
   ) u_fmt (
      .mode_i  (mode_q),
      .ctx_i   (ctx_q),
      .iter_i  (iter),
      .chain_i (chain_q),
      .seed_i  (seed_q),
      .blk_o   (req_block_o),
      .init_o  (req_state_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= HC_IDLE;
      end else begin
         unique case (st_q)
            HC_IDLE, HC_DONE: if (start_i) st_q <= none ? HC_DONE : HC_REQ;
            HC_REQ:           if (req_ready_i) st_q <= HC_WAIT;
            HC_WAIT:          if (rsp_valid_i) st_q <= last ? HC_DONE : HC_REQ;
            default:          st_q <= HC_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         seed_q  <= '0;
         ctx_q   <= '0;
         mode_q  <= 1'b0;
      end else if (accept) begin
         chain_q <= node_i;
         seed_q  <= seed_state_i;
         ctx_q   <= ctx_i;
         mode_q  <= mode_i;
      end else if (adv) begin
         chain_q <= rsp_state_i;
      end
   end

   assign req_valid_o = (st_q == HC_REQ);
   assign done_o      = (st_q == HC_DONE);
   assign result_o    = chain_q;

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=>
         (req_valid_o && $stable(req_block_o) && $stable(req_state_o)));

   assert_idle_when_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_valid_o);

   assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(result_o)));

   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HC_WAIT && start_i && !rsp_valid_i) |=>
         (st_q == HC_WAIT && $stable(chain_q) && $stable(req_block_o)));

   assert_empty_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && none) |=> (done_o && result_o == $past(node_i)));

   assert_rsp_in_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_i |-> (st_q == HC_WAIT));
endmodule

// File: tb/tb_hc_chain_seq.sv
`timescale 1ns/1ps
module tb_hc_chain_seq;
   localparam logic [255:0] IV = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         mode_i = 1'b0;
   logic [1:0]   wsel_i = 2'd0;
   logic [7:0]   chunk_i = 8'd0;
   logic [255:0] node_i = '0;
   logic [175:0] ctx_i = '0;
   logic [255:0] seed_state_i = '0;
   logic         req_valid_o;
   logic         req_ready_i = 1'b0;
   logic [255:0] req_state_o;
   logic [511:0] req_block_o;
   logic         rsp_valid_i = 1'b0;
   logic [255:0] rsp_state_i = '0;
   logic         done_o;
   logic [255:0] result_o;

   int n_vec = 0;
   int n_bad = 0;
   int nreq  = 0;
   int steps_seen = 0;

   bit           exp_mode;
   logic [175:0] exp_ctx;
   logic [255:0] exp_seed;
   logic [7:0]   exp_iter;
   logic [255:0] exp_chain;

   always #5 clk = ~clk;

   hc_chain_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .wsel_i(wsel_i), .chunk_i(chunk_i), .node_i(node_i), .ctx_i(ctx_i),
      .seed_state_i(seed_state_i), .req_valid_o(req_valid_o),
      .req_ready_i(req_ready_i), .req_state_o(req_state_o),
      .req_block_o(req_block_o), .rsp_valid_i(rsp_valid_i),
      .rsp_state_i(rsp_state_i), .done_o(done_o), .result_o(result_o));

   function automatic logic [511:0] want_block(input bit m, input logic [175:0] c,
                                               input logic [7:0] it, input logic [255:0] ch);
      if (!m) return {c, it, ch, 8'h80, 64'd440};
      return {c[175:32], 24'h0, it, ch, 8'h80, 8'h00, 64'd944};
   endfunction

   function automatic logic [255:0] cmodel(input logic [255:0] st, input logic [511:0] b);
      logic [255:0] r;
      logic [31:0]  s, x, y;
      for (int i = 0; i < 8; i++) begin
         s = st[255-32*i -: 32];
         x = b[511-32*i -: 32];
         y = b[255-32*i -: 32];
         r[255-32*i -: 32] = s + (x ^ {y[30:0], y[31]}) + 32'(i * 7 + 1);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [511:0] act, input logic [511:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // compression unit model
   initial begin
      logic [511:0] hb, eb;
      logic [255:0] hs, es;
      int gap, lat;
      forever begin
         @(negedge clk);
         if (rst_n && req_valid_o) begin
            gap = nreq % 3;
            lat = 1 + (nreq % 2);
            hb = req_block_o;
            hs = req_state_o;
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               check(req_valid_o && req_block_o === hb && req_state_o === hs,
                     "R7", "request held", {req_state_o, 255'(req_block_o), req_valid_o},
                     {hs, 255'(hb), 1'b1});
            end
            req_ready_i = 1'b1;
            eb = want_block(exp_mode, exp_ctx, exp_iter, exp_chain);
            es = exp_mode ? exp_seed : IV;
            check(req_block_o === eb, exp_mode ? "R3 R4 R5" : "R2 R4 R5",
                  "request block", req_block_o, eb);
            check(req_state_o === es, "R3", "request state",
                  512'(req_state_o), 512'(es));
            @(negedge clk);
            req_ready_i = 1'b0;
            for (int l = 1; l < lat; l++) @(negedge clk);
            rsp_state_i = cmodel(es, eb);
            exp_chain   = rsp_state_i;
            exp_iter    = exp_iter + 8'd1;
            steps_seen++;
            nreq++;
            rsp_valid_i = 1'b1;
            @(negedge clk);
            rsp_valid_i = 1'b0;
         end
      end
   end

   task automatic run_chain(input bit m, input logic [1:0] ws, input logic [7:0] ch,
                            input logic [255:0] nd, input logic [175:0] cx,
                            input logic [255:0] sd, input bit poke);
      logic [7:0] mask, a, steps;
      logic [255:0] held;
      int t;
      mask  = (ws == 2'd0) ? 8'd3 : (ws == 2'd1) ? 8'd15 : 8'd255;
      a     = ch & mask;
      steps = mask - a;
      @(negedge clk);
      exp_mode = m; exp_ctx = cx; exp_seed = sd; exp_iter = a; exp_chain = nd;
      steps_seen = 0;
      mode_i = m; wsel_i = ws; chunk_i = ch; node_i = nd; ctx_i = cx;
      seed_state_i = sd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (steps == 0) begin
         check(done_o === 1'b1, "R6", "done one cycle after start", 512'(done_o), 512'(1));
         check(result_o === nd, "R6", "unchanged node", 512'(result_o), 512'(nd));
      end else begin
         check(done_o === 1'b0, "R9", "start clears done", 512'(done_o), 512'(0));
      end
      if (poke && steps >= 3) begin
         @(negedge clk);
         start_i = 1'b1; node_i = ~nd; chunk_i = 8'd0; mode_i = ~m;
         ctx_i = ~cx; seed_state_i = ~sd;
         @(negedge clk);
         start_i = 1'b0;
      end
      t = 0;
      while (!done_o && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(t < 5000, "R1", "chain completes", 512'(t), 512'(0));
      check(steps_seen == int'(steps), "R1", "compression count",
            512'(steps_seen), 512'(steps));
      check(result_o === exp_chain, "R5", "chain end value", 512'(result_o), 512'(exp_chain));
      held = result_o;
      chunk_i = ~ch; node_i = ~nd; mode_i = ~m;
      for (int k = 0; k < 3; k++) @(negedge clk);
      check(done_o === 1'b1 && result_o === held && !req_valid_o, "R9",
            "done and result held", {255'(result_o), done_o}, {255'(held), 1'b1});
      if (poke) check(steps_seen == int'(steps), "R8", "busy start ignored",
                      512'(steps_seen), 512'(steps));
   endtask

   initial begin
      logic [7:0] mask;
      logic [255:0] nd, sd;
      logic [175:0] cx;
      int run;
      run = 0;
      repeat (3) @(negedge clk);
      check(done_o === 1'b0 && req_valid_o === 1'b0, "R10", "reset outputs",
            {510'(0), done_o, req_valid_o}, 512'(0));
      check(result_o === '0, "R10", "reset result", 512'(result_o), 512'(0));
      rst_n = 1'b1;
      for (int m = 0; m < 2; m++) begin
         for (int ws = 0; ws < 4; ws++) begin
            mask = (ws == 0) ? 8'd3 : (ws == 1) ? 8'd15 : 8'd255;
            for (int a = 0; a <= int'(mask) + 1; a += (mask == 8'd255) ? 15 : 1) begin
               logic [7:0] av;
               av = (a > int'(mask)) ? mask - 8'd1 : 8'(a);
               if (a == 255) av = 8'd255;
               run++;
               nd = {8{32'h9e3779b9 * 32'(run)}} ^ {32'(run), 224'h0};
               sd = {8{32'h85ebca6b ^ 32'(run * 3)}};
               cx = {11{16'h1357 + 16'(run)}};
               // R1: high chunk bits must be masked away
               run_chain(m[0], 2'(ws), av | (~mask & 8'hA4), nd, cx, sd, 1'b1);
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule